// File: doc/BRIEF.md
# ATA Task-File Register Bank

This block is the byte-wide register bank on the host side of a two-device ATA channel. It keeps a full set of task-file registers for each of the two devices, together with a one-deep shadow of every addressable task-file byte for 48-bit addressing, a drive/head register per device, and a device control register. A host write to a task-file register lands in both devices in the same cycle, and the value it replaces moves into the shadow. The bank also tracks which device is selected. It drives the single channel interrupt line from the per-device pending flags and the interrupt-mask bit. It produces one-cycle pulses when software reset is entered and when it is left.

The host bus is a plain address/data bus with a write strobe. Reads are combinational and have no side effects. A select input chooses between the seven task-file offsets and the control port. Command decoding, data transfer and the per-device state machines sit outside this block. They supply the interrupt-pending flags and the device-kind straps, and they consume the reset pulses. The reset-entry pulse is also the signal to flush any queued work.

Top module: `ata_taskfile_bank`

## Requirements
- R1: A host write with `hostCtlSel`=0 to offset 1 (features), 2 (sector count), 3 (sector number), 4 (cylinder low) or 5 (cylinder high) copies that register's current value into its shadow and stores the new byte. Both devices are updated in the same clock edge.
- R2: Any write to offsets 1 to 5 clears bit 7 (shadow-select) of the device control register of both devices.
- R3: The read path is combinational and follows the selected device. Offset 0 reads 0x00 and offset 1 reads the error register. Offsets 2 to 5 read the shadow when control bit 7 is set and the current value otherwise. Offset 6 reads the drive/head copy, and both offset 7 and the control port read the status register.
- R4: A write to offset 6 stores two drive/head copies, each ORed with 0xA0. Device 0's copy has bit 4 cleared and device 1's copy has bit 4 set.
- R5: Bit 4 of a byte written to offset 6 becomes the selected-device index from the next cycle on.
- R6: One cycle after any input change or write, `irqOut` equals the selected device's pending flag ANDed with the inverse of control bit 1 (interrupt mask). A select change or a mask toggle therefore raises or drops the line accordingly.
- R7: A control-port write stores the byte in both devices. If it moves bit 2 (soft reset) from 0 to 1, both status registers become 0x90 (busy, seek-complete) and both error registers become 0x01. In that case `resetStartPulse` is high for the cycle after the write.
- R8: A control-port write that moves bit 2 from 1 to 0 raises `resetEndPulse` for the cycle after the write. Each status register then reads 0x50 (ready, seek-complete) for a device whose `devIsPacket` bit is 0, and 0x00 for a packet device.
- R9: Each reset pulse lasts exactly one cycle. The two pulses never occur together. A control write that leaves bit 2 unchanged produces neither pulse.
- R10: After `rstN` is low, the current and shadow registers read 0x00. The drive/head copies are 0xA0 and 0xB0, device 0 is selected and device control is 0x00. Status is 0x50 (ATA) or 0x00 (packet), error is 0x01 and `irqOut` is 0.
- R11: Writes to offset 0 or offset 7 change no register in the bank.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| hostAddr | input | 3 | Task-file offset 0 to 7 |
| hostCtlSel | input | 1 | 1 selects the control port instead of the task file |
| hostWr | input | 1 | Write strobe, one cycle per write |
| hostWrData | input | 8 | Write data |
| hostRdData | output | 8 | Combinational read data for the selected device |
| devIrqPend | input | 2 | Interrupt-pending flag per device |
| devIsPacket | input | 2 | 1 marks a packet device (static strap) |
| irqOut | output | 1 | Channel interrupt line |
| resetStartPulse | output | 1 | One-cycle pulse on soft-reset entry, also flushes queued work |
| resetEndPulse | output | 1 | One-cycle pulse on soft-reset exit |

## Verification
The bench goes after the shadow chain. After two writes to the same offset, the shadow must hold the first byte. A design that captures the incoming byte or shadows the wrong index returns the second value or a stale neighbour once the shadow-select bit is set. It also checks the asymmetric drive/head copies and the select change. A design that forces bit 4 the same way on both devices, or that takes the select from the wrong bit, reads back a drive/head value that does not match the device it claims to serve. The interrupt line is driven through select changes with unequal pending flags and through mask toggles. A design that latches the line only on pending changes would keep a stale level. Control writes that leave the soft-reset bit unchanged must produce no pulse, which exposes a level-sensitive detector. The exit status must differ by device kind, which exposes a design that gives packet devices the ready bit.

// File: rtl/tfb_pkg.sv
package tfb_pkg;
  localparam int DW      = 8;
  localparam int AW      = 3;
  localparam int NUM_DEV = 2;
  localparam int SEL_W   = $clog2(NUM_DEV);
  localparam int NUM_TF  = 5;

  // control byte fields
  localparam int CTL_NIEN = 1;
  localparam int CTL_SRST = 2;
  localparam int CTL_HOB  = 7;
  // status byte fields
  localparam int ST_DSC  = 4;
  localparam int ST_DRDY = 6;
  localparam int ST_BSY  = 7;
  // drive/head field
  localparam int DH_DEV = 4;

  // host offsets
  localparam logic [AW-1:0] OFF_ERR   = AW'(1);
  localparam logic [AW-1:0] OFF_TF_LO = AW'(1);
  localparam logic [AW-1:0] OFF_TF_HI = AW'(5);
  localparam logic [AW-1:0] OFF_DH    = AW'(6);
  localparam logic [AW-1:0] OFF_STAT  = AW'(7);

  localparam logic [DW-1:0] ST_RESET_VAL = DW'((1 << ST_BSY) | (1 << ST_DSC));
  localparam logic [DW-1:0] ST_IDLE_ATA  = DW'((1 << ST_DRDY) | (1 << ST_DSC));
  localparam logic [DW-1:0] ER_RESET_VAL = DW'(1);
  localparam logic [DW-1:0] DH_FORCE     = DW'(8'hA0);
  localparam logic [DW-1:0] DH_DEV_MASK  = DW'(1 << DH_DEV);

  typedef struct packed {
    logic                    tfWr;
    logic [AW-1:0]           tfIdx;
    logic                    dhWr;
    logic                    ctlWr;
    logic                    rstEnter;
    logic                    rstLeave;
    logic [DW-1:0]           data;
  } tfb_strobe_t;
endpackage

// File: rtl/tfb_ctrl.sv
module tfb_ctrl
  import tfb_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic [AW-1:0]      hostAddr,
  input  logic               hostCtlSel,
  input  logic               hostWr,
  input  logic [DW-1:0]      hostWrData,
  input  logic [NUM_DEV-1:0] devIrqPend,
  input  logic [DW-1:0]      devCtlQ,
  output tfb_strobe_t        strb,
  output logic [SEL_W-1:0]   selQ,
  output logic               irqOut,
  output logic               resetStartPulse,
  output logic               resetEndPulse
);
  logic [SEL_W-1:0] selNext;
  logic             nienNext;

  // decode host access into datapath strobes
  always_comb begin
    strb      = '0;
    strb.data = hostWrData;
    if (hostWr) begin
      if (hostCtlSel) begin
        strb.ctlWr    = 1'b1;
        strb.rstEnter = hostWrData[CTL_SRST] & ~devCtlQ[CTL_SRST];
        strb.rstLeave = ~hostWrData[CTL_SRST] & devCtlQ[CTL_SRST];
      end else if (hostAddr >= OFF_TF_LO && hostAddr <= OFF_TF_HI) begin
        strb.tfWr  = 1'b1;
        strb.tfIdx = hostAddr - OFF_TF_LO;
      end else if (hostAddr == OFF_DH) begin
        strb.dhWr = 1'b1;
      end
    end
  end

  // select and mask values in effect after this edge
  always_comb begin
    selNext  = strb.dhWr  ? SEL_W'(hostWrData[DH_DEV]) : selQ;
    nienNext = strb.ctlWr ? hostWrData[CTL_NIEN]       : devCtlQ[CTL_NIEN];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      selQ            <= '0;
      irqOut          <= 1'b0;
      resetStartPulse <= 1'b0;
      resetEndPulse   <= 1'b0;
    end else begin
      selQ            <= selNext;
      irqOut          <= devIrqPend[selNext] & ~nienNext;
      resetStartPulse <= strb.rstEnter;
      resetEndPulse   <= strb.rstLeave;
    end
  end
endmodule

// File: rtl/tfb_regs.sv
module tfb_regs
  import tfb_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  tfb_strobe_t        strb,
  input  logic [SEL_W-1:0]   selQ,
  input  logic [NUM_DEV-1:0] devIsPacket,
  input  logic [AW-1:0]      hostAddr,
  input  logic               hostCtlSel,
  output logic [DW-1:0]      hostRdData,
  output logic [DW-1:0]      devCtl0
);
  logic [DW-1:0] rdDev [NUM_DEV];
  logic [DW-1:0] dcDev [NUM_DEV];

  for (genvar d = 0; d < NUM_DEV; d++) begin : g_dev
    localparam logic [DW-1:0] DEV_BIT = (d != 0) ? DH_DEV_MASK : '0;

    logic [DW-1:0] cur [NUM_TF];
    logic [DW-1:0] hob [NUM_TF];
    logic [DW-1:0] dh;
    logic [DW-1:0] dc;
    logic [DW-1:0] st;
    logic [DW-1:0] er;
    logic [DW-1:0] stIdle;
    logic [DW-1:0] rd;

    assign stIdle = devIsPacket[d] ? '0 : ST_IDLE_ATA;

    always_ff @(posedge clk) begin
      if (!rstN) begin
        for (int i = 0; i < NUM_TF; i++) begin
          cur[i] <= '0;
          hob[i] <= '0;
        end
        dh <= DH_FORCE | DEV_BIT;
        dc <= '0;
        st <= stIdle;
        er <= ER_RESET_VAL;
      end else begin
        if (strb.tfWr) begin
          hob[strb.tfIdx] <= cur[strb.tfIdx];
          cur[strb.tfIdx] <= strb.data;
          dc[CTL_HOB]     <= 1'b0;
        end
        if (strb.dhWr) dh <= (strb.data & ~DH_DEV_MASK) | DH_FORCE | DEV_BIT;
        if (strb.ctlWr) dc <= strb.data;
        if (strb.rstEnter) begin
          st <= ST_RESET_VAL;
          er <= ER_RESET_VAL;
        end
        if (strb.rstLeave) st <= stIdle;
      end
    end

    always_comb begin
      rd = '0;
      if (hostCtlSel) begin
        rd = st;
      end else if (hostAddr == OFF_ERR) begin
        rd = er;
      end else if (hostAddr > OFF_TF_LO && hostAddr <= OFF_TF_HI) begin
        rd = dc[CTL_HOB] ? hob[hostAddr - OFF_TF_LO] : cur[hostAddr - OFF_TF_LO];
      end else if (hostAddr == OFF_DH) begin
        rd = dh;
      end else if (hostAddr == OFF_STAT) begin
        rd = st;
      end
    end

    assign rdDev[d] = rd;
    assign dcDev[d] = dc;
  end

  assign hostRdData = rdDev[selQ];
  assign devCtl0    = dcDev[0];
endmodule

// File: rtl/ata_taskfile_bank.sv
module ata_taskfile_bank
  import tfb_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic [AW-1:0]      hostAddr,
  input  logic               hostCtlSel,
  input  logic               hostWr,
  input  logic [DW-1:0]      hostWrData,
  output logic [DW-1:0]      hostRdData,
  input  logic [NUM_DEV-1:0] devIrqPend,
  input  logic [NUM_DEV-1:0] devIsPacket,
  output logic               irqOut,
  output logic               resetStartPulse,
  output logic               resetEndPulse
);
  tfb_strobe_t      strb;
  logic [SEL_W-1:0] selQ;
  logic [DW-1:0]    devCtl0;

  tfb_ctrl u_ctrl (
    .clk            (clk),
    .rstN           (rstN),
    .hostAddr       (hostAddr),
    .hostCtlSel     (hostCtlSel),
    .hostWr         (hostWr),
    .hostWrData     (hostWrData),
    .devIrqPend     (devIrqPend),
    .devCtlQ        (devCtl0),
    .strb           (strb),
    .selQ           (selQ),
    .irqOut         (irqOut),
    .resetStartPulse(resetStartPulse),
    .resetEndPulse  (resetEndPulse)
  );

  tfb_regs u_regs (
    .clk        (clk),
    .rstN       (rstN),
    .strb       (strb),
    .selQ       (selQ),
    .devIsPacket(devIsPacket),
    .hostAddr   (hostAddr),
    .hostCtlSel (hostCtlSel),
    .hostRdData (hostRdData),
    .devCtl0    (devCtl0)
  );
endmodule

// File: rtl/tfb_checker.sv
module tfb_checker
  import tfb_pkg::*;
(
  input logic             clk,
  input logic             rstN,
  input logic [AW-1:0]    hostAddr,
  input logic             hostCtlSel,
  input logic             hostWr,
  input logic [DW-1:0]    hostWrData,
  input logic             irqOut,
  input logic             resetStartPulse,
  input logic             resetEndPulse,
  input logic [SEL_W-1:0] selQ,
  input logic [DW-1:0]    devCtlQ
);
  logic tfWrite;
  assign tfWrite = hostWr && !hostCtlSel && hostAddr >= OFF_TF_LO && hostAddr <= OFF_TF_HI;

  a_r2_hob_cleared: assert property (@(posedge clk) disable iff (!rstN)
    tfWrite |=> !devCtlQ[CTL_HOB]);

  a_r5_select_follows_write: assert property (@(posedge clk) disable iff (!rstN)
    (hostWr && !hostCtlSel && hostAddr == OFF_DH) |=> selQ == SEL_W'($past(hostWrData[DH_DEV])));

  a_r6_masked_quiet: assert property (@(posedge clk) disable iff (!rstN)
    (hostWr && hostCtlSel && hostWrData[CTL_NIEN]) |=> !irqOut);

  a_r7_start_pulse: assert property (@(posedge clk) disable iff (!rstN)
    (hostWr && hostCtlSel && hostWrData[CTL_SRST] && !devCtlQ[CTL_SRST]) |=> resetStartPulse);

  a_r8_end_pulse: assert property (@(posedge clk) disable iff (!rstN)
    (hostWr && hostCtlSel && !hostWrData[CTL_SRST] && devCtlQ[CTL_SRST]) |=> resetEndPulse);

  a_r9_start_single: assert property (@(posedge clk) disable iff (!rstN)
    resetStartPulse |=> !resetStartPulse);

  a_r9_end_single: assert property (@(posedge clk) disable iff (!rstN)
    resetEndPulse |=> !resetEndPulse);

  a_r9_no_overlap: assert property (@(posedge clk) disable iff (!rstN)
    !(resetStartPulse && resetEndPulse));

  a_r9_unchanged_silent: assert property (@(posedge clk) disable iff (!rstN)
    (hostWr && hostCtlSel && hostWrData[CTL_SRST] == devCtlQ[CTL_SRST])
      |=> (!resetStartPulse && !resetEndPulse));
endmodule

bind ata_taskfile_bank tfb_checker u_chk (
  .clk            (clk),
  .rstN           (rstN),
  .hostAddr       (hostAddr),
  .hostCtlSel     (hostCtlSel),
  .hostWr         (hostWr),
  .hostWrData     (hostWrData),
  .irqOut         (irqOut),
  .resetStartPulse(resetStartPulse),
  .resetEndPulse  (resetEndPulse),
  .selQ           (selQ),
  .devCtlQ        (devCtl0)
);

// File: tb/ata_taskfile_bank_tb.sv
module ata_taskfile_bank_tb;
  localparam int CLK_PERIOD = 40;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [2:0] hostAddr = '0;
  logic       hostCtlSel = 1'b0;
  logic       hostWr = 1'b0;
  logic [7:0] hostWrData = '0;
  logic [7:0] hostRdData;
  logic [1:0] devIrqPend = '0;
  logic [1:0] devIsPacket = 2'b10;
  logic       irqOut;
  logic       resetStartPulse;
  logic       resetEndPulse;

  int checks = 0;
  int failures = 0;

  // bench model
  logic [7:0] mCur [2][5];
  logic [7:0] mHob [2][5];
  logic [7:0] mDh [2];
  logic [7:0] mSt [2];
  logic [7:0] mEr [2];
  logic [7:0] mDc;
  int         mSel;
  logic       expStart, expEnd;

  always #(CLK_PERIOD/2) clk = ~clk;

  ata_taskfile_bank u_dut (
    .clk(clk), .rstN(rstN), .hostAddr(hostAddr), .hostCtlSel(hostCtlSel),
    .hostWr(hostWr), .hostWrData(hostWrData), .hostRdData(hostRdData),
    .devIrqPend(devIrqPend), .devIsPacket(devIsPacket), .irqOut(irqOut),
    .resetStartPulse(resetStartPulse), .resetEndPulse(resetEndPulse)
  );

  function automatic logic [7:0] idleStatus(int d);
    return devIsPacket[d] ? 8'h00 : 8'h50;
  endfunction

  function automatic logic [7:0] expRead(bit ctl, int a);
    if (ctl) return mSt[mSel];
    case (a)
      0: return 8'h00;
      1: return mEr[mSel];
      2, 3, 4, 5: return mDc[7] ? mHob[mSel][a-1] : mCur[mSel][a-1];
      6: return mDh[mSel];
      default: return mSt[mSel];
    endcase
  endfunction

  function automatic logic expIrq();
    return devIrqPend[mSel] & ~mDc[1];
  endfunction

  task automatic check(string tag, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%02h expected=%02h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic modelReset();
    for (int d = 0; d < 2; d++) begin
      for (int i = 0; i < 5; i++) begin
        mCur[d][i] = 8'h00;
        mHob[d][i] = 8'h00;
      end
      mSt[d] = idleStatus(d);
      mEr[d] = 8'h01;
    end
    mDh[0] = 8'hA0;
    mDh[1] = 8'hB0;
    mDc = 8'h00;
    mSel = 0;
  endtask

  // reads every offset and the control port within one clock low phase
  task automatic readAll(string tag);
    for (int a = 0; a < 8; a++) begin
      hostCtlSel = 1'b0;
      hostAddr = a[2:0];
      #1;
      check(tag, hostRdData, expRead(1'b0, a));
    end
    hostCtlSel = 1'b1;
    #1;
    check(tag, hostRdData, expRead(1'b1, 0));
    hostCtlSel = 1'b0;
  endtask

  task automatic hostWrite(bit ctl, int a, logic [7:0] d, string tag);
    @(negedge clk);
    hostCtlSel = ctl;
    hostAddr = a[2:0];
    hostWrData = d;
    hostWr = 1'b1;
    @(negedge clk);
    hostWr = 1'b0;
    expStart = 1'b0;
    expEnd = 1'b0;
    if (ctl) begin
      expStart = d[2] & ~mDc[2];
      expEnd = ~d[2] & mDc[2];
      mDc = d;
      for (int k = 0; k < 2; k++) begin
        if (expStart) begin
          mSt[k] = 8'h90;
          mEr[k] = 8'h01;
        end
        if (expEnd) mSt[k] = idleStatus(k);
      end
    end else if (a >= 1 && a <= 5) begin
      for (int k = 0; k < 2; k++) begin
        mHob[k][a-1] = mCur[k][a-1];
        mCur[k][a-1] = d;
      end
      mDc[7] = 1'b0;
    end else if (a == 6) begin
      mDh[0] = (d & 8'hEF) | 8'hA0;
      mDh[1] = d | 8'hB0;
      mSel = int'(d[4]);
    end
    check("R9 start pulse", {7'b0, resetStartPulse}, {7'b0, expStart});
    check("R9 end pulse", {7'b0, resetEndPulse}, {7'b0, expEnd});
    check("R6 irq", {7'b0, irqOut}, {7'b0, expIrq()});
    readAll(tag);
  endtask

  task automatic setPend(logic [1:0] p);
    @(negedge clk);
    devIrqPend = p;
    @(negedge clk);
    check("R6 irq after pending change", {7'b0, irqOut}, {7'b0, expIrq()});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED1234));
    modelReset();
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R10 reset state
    check("R10 irq at reset", {7'b0, irqOut}, 8'h00);
    readAll("R10 reset state");

    // R1 shadow chain, R2 HOB clear, R3 read selection
    hostWrite(1'b0, 2, 8'h11, "R1 first write");
    hostWrite(1'b0, 2, 8'h22, "R1 second write");
    hostWrite(1'b1, 0, 8'h80, "R3 shadow view");
    check("R3 shadow read", expRead(1'b0, 2), 8'h11);
    hostWrite(1'b0, 5, 8'h5A, "R2 write clears shadow view");
    check("R2 hob bit cleared", mDc, 8'h00);

    // R4 and R5 drive/head copies and selection
    hostWrite(1'b0, 6, 8'h1F, "R5 select device 1");
    check("R4 device 1 copy", mDh[1], 8'hBF);
    hostWrite(1'b0, 6, 8'h0E, "R4 select device 0");

    // R6 interrupt through select change and mask toggle
    setPend(2'b01);
    hostWrite(1'b0, 6, 8'h10, "R6 select drops irq");
    hostWrite(1'b0, 6, 8'h00, "R6 select raises irq");
    hostWrite(1'b1, 0, 8'h02, "R6 mask drops irq");
    hostWrite(1'b1, 0, 8'h00, "R6 unmask raises irq");
    setPend(2'b00);

    // R7 and R8 soft reset entry and exit, R9 unchanged bit
    hostWrite(1'b1, 0, 8'h04, "R7 reset entry");
    hostWrite(1'b1, 0, 8'h06, "R9 bit unchanged");
    hostWrite(1'b0, 6, 8'h10, "R7 device 1 in reset");
    hostWrite(1'b1, 0, 8'h00, "R8 reset exit packet");
    hostWrite(1'b0, 6, 8'h00, "R8 reset exit ata");

    // R11 command and data offsets ignored
    hostWrite(1'b0, 7, 8'hEC, "R11 command write ignored");
    hostWrite(1'b0, 0, 8'h33, "R11 data write ignored");

    // constrained random mix
    for (int n = 0; n < 400; n++) begin
      int op;
      logic [7:0] d;
      op = int'($urandom % 10);
      d = 8'($urandom);
      case (op)
        0, 1, 2, 3, 4: hostWrite(1'b0, 1 + int'($urandom % 5), d, "R1 random task-file");
        5: hostWrite(1'b0, 6, d, "R4 random drive/head");
        6: hostWrite(1'b1, 0, d & 8'h86, "R7 random control");
        7: setPend(2'($urandom));
        8: hostWrite(1'b0, ($urandom % 2 == 0) ? 0 : 7, d, "R11 random ignored");
        default: hostWrite(1'b1, 0, (mDc & 8'h06) | 8'h80, "R3 random shadow view");
      endcase
    end

    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule